// File: doc/BRIEF.md
# Width-Relative Sign Extension Unit

This unit sign-extends a narrow field of a register operand up to the full datapath width `XLEN`. `XLEN` is a build parameter and may be 8, 16, 32 or 64. A 2-bit opcode selects the field. In the three scaled modes the field width is a fixed fraction of `XLEN`, not a fixed count of bits. The "byte" mode takes one eighth of `XLEN`, the "half" mode one quarter and the "word" mode one half. At `XLEN`=64 this gives the usual 8/16/32-bit extension. At `XLEN`=8 the same opcodes extend 1, 2 and 4 bits.

Opcode 3 selects a fixed-width compatibility mode. In that mode a second select input picks a literal field of 8, 16 or 32 bits, or the whole register. A literal field that is as wide as the register, or wider, leaves the operand unchanged, because the wider field is truncated to `XLEN`.

The result is registered. It appears with a valid flag one clock after the input is accepted. A two-state machine sequences the output. `ST_IDLE` means no result is being presented. `ST_EMIT` means the result register holds a fresh result. The transition `accept` goes to `ST_EMIT` on any cycle with `in_valid` high, from either state. The transition `drain` goes to `ST_IDLE` on any cycle with `in_valid` low.

Top module: `wsx_unit`

## Requirements
- R1: With `in_op`=0 (byte mode), the result is the low `XLEN/8` bits of `in_data` sign-extended to `XLEN` bits. All higher input bits are ignored.
- R2: With `in_op`=1 (half mode), the result is the low `XLEN/4` bits of `in_data` sign-extended to `XLEN` bits.
- R3: With `in_op`=2 (word mode), the result is the low `XLEN/2` bits of `in_data` sign-extended to `XLEN` bits.
- R4: In every mode, the result bits below the field width equal the input bits, and every bit above the field equals the field's top bit.
- R5: With `in_op`=3 (fixed mode), `in_fix_sel` picks a literal field width: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits and 3 selects `XLEN` bits. A literal field narrower than `XLEN` is sign-extended. `in_fix_sel` has no effect when `in_op` is not 3.
- R6: In fixed mode, when the literal field width is greater than or equal to `XLEN`, `out_data` equals `in_data` unchanged.
- R7: A cycle with `in_valid` high gives `out_valid` high and the result on `out_data` after the next rising clock edge. A cycle with `in_valid` low gives `out_valid` low after the next edge.
- R8: While `in_valid` is low, `out_data` keeps its last value.
- R9: During reset (`rst_n` low), `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and opcode are valid this cycle |
| in_op | input | 2 | Mode: 0 byte, 1 half, 2 word, 3 fixed |
| in_fix_sel | input | 2 | Fixed-mode literal width: 0 = 8, 1 = 16, 2 = 32, 3 = XLEN |
| in_data | input | XLEN | Register operand |
| out_valid | output | 1 | `out_data` holds a fresh result |
| out_data | output | XLEN | Registered sign-extended result |

## Verification
The embedded properties check the following on every clock:
- the one-cycle valid pipeline;
- the holding of `out_data` while no input is offered;
- for each scaled mode, the copied low bits and the uniform upper bits;
- the full-width pass-through of the fixed mode.

The bench runs the unit at all four `XLEN` values against an independent shift-based model. Only its scenarios can show that the field width chosen per mode and per literal select is the right one. They also show that junk above the field is ignored and that positive, negative, zero and all-ones fields extend correctly. They cover the narrow cases where a mode's field is a single bit and where a fixed literal reaches or exceeds the register width.

// File: rtl/wsx_pkg.sv
package wsx_pkg;

    typedef enum logic [1:0] {
        OP_BYTE  = 2'd0,
        OP_HALF  = 2'd1,
        OP_WORD  = 2'd2,
        OP_FIXED = 2'd3
    } wsx_op_e;

    typedef enum logic [1:0] {
        FX_8    = 2'd0,
        FX_16   = 2'd1,
        FX_32   = 2'd2,
        FX_FULL = 2'd3
    } wsx_fix_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } wsx_state_e;

    function automatic int clamp_width(input int lit, input int xlen);
        return (lit >= xlen) ? xlen : lit;
    endfunction

endpackage

// File: rtl/wsx_width_sel.sv
module wsx_width_sel
    import wsx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WW   = $clog2(XLEN + 1)
) (
    input  logic [1:0]    op,
    input  logic [1:0]    fix_sel,
    output logic [WW-1:0] width
);
    localparam logic [WW-1:0] W_BYTE = WW'(XLEN / 8);
    localparam logic [WW-1:0] W_HALF = WW'(XLEN / 4);
    localparam logic [WW-1:0] W_WORD = WW'(XLEN / 2);
    localparam logic [WW-1:0] W_F8   = WW'(clamp_width(8, XLEN));
    localparam logic [WW-1:0] W_F16  = WW'(clamp_width(16, XLEN));
    localparam logic [WW-1:0] W_F32  = WW'(clamp_width(32, XLEN));
    localparam logic [WW-1:0] W_FULL = WW'(XLEN);

    logic [WW-1:0] fixed_w;

    always_comb begin
        unique case (wsx_fix_e'(fix_sel))
            FX_8:    fixed_w = W_F8;
            FX_16:   fixed_w = W_F16;
            FX_32:   fixed_w = W_F32;
            FX_FULL: fixed_w = W_FULL;
            default: fixed_w = W_FULL;
        endcase
    end

    always_comb begin
        unique case (wsx_op_e'(op))
            OP_BYTE:  width = W_BYTE;
            OP_HALF:  width = W_HALF;
            OP_WORD:  width = W_WORD;
            OP_FIXED: width = fixed_w;
            default:  width = W_FULL;
        endcase
    end

    // R5: the selected width is never zero and never exceeds the register
    always_comb begin
        width_range_chk: assert (width >= WW'(1) && width <= W_FULL || $isunknown(width));
    end

endmodule

// File: rtl/wsx_extender.sv
module wsx_extender #(
    parameter int XLEN = 64,
    parameter int WW   = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] data,
    input  logic [WW-1:0]   width,
    output logic [XLEN-1:0] result
);
    logic sign_bit;

    // pick the top bit of the field
    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (WW'(i + 1) == width) sign_bit = data[i];
        end
    end

    // copy bits inside the field, replicate the sign above it
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            result[i] = (WW'(i) < width) ? data[i] : sign_bit;
        end
    end

endmodule

// File: rtl/wsx_unit.sv
module wsx_unit
    import wsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [1:0]      in_fix_sel,
    input  logic [XLEN-1:0] in_data,
    output logic            out_valid,
    output logic [XLEN-1:0] out_data
);
    localparam int WW = $clog2(XLEN + 1);
    localparam int BW = XLEN / 8;
    localparam int HW = XLEN / 4;
    localparam int DW = XLEN / 2;

    wsx_state_e      state_q, state_d;
    logic [WW-1:0]   field_w;
    logic [XLEN-1:0] ext_res;
    logic [XLEN-1:0] data_q;

    wsx_width_sel #(.XLEN(XLEN), .WW(WW)) u_wsel (
        .op      (in_op),
        .fix_sel (in_fix_sel),
        .width   (field_w)
    );

    wsx_extender #(.XLEN(XLEN), .WW(WW)) u_ext (
        .data   (in_data),
        .width  (field_w),
        .result (ext_res)
    );

    // next-state: accept / drain
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (in_valid) data_q <= ext_res;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_data  = data_q;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R1 R4
    byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == OP_BYTE) |->
        (out_data[BW-1:0] == $past(in_data[BW-1:0]) &&
         ((&out_data[XLEN-1:BW-1]) || !(|out_data[XLEN-1:BW-1]))));

    // R2 R4
    half_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == OP_HALF) |->
        (out_data[HW-1:0] == $past(in_data[HW-1:0]) &&
         ((&out_data[XLEN-1:HW-1]) || !(|out_data[XLEN-1:HW-1]))));

    // R3 R4
    word_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == OP_WORD) |->
        (out_data[DW-1:0] == $past(in_data[DW-1:0]) &&
         ((&out_data[XLEN-1:DW-1]) || !(|out_data[XLEN-1:DW-1]))));

    // R6
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == OP_FIXED && $past(in_fix_sel) == FX_FULL) |->
        out_data == $past(in_data));

endmodule

// File: tb/wsx_unit_tb_top.sv
module wsx_unit_tb #(
    parameter int XLEN = 64
) (
    input logic clk,
    input logic rst_n
);
    logic            in_valid;
    logic [1:0]      in_op;
    logic [1:0]      in_fix_sel;
    logic [XLEN-1:0] in_data;
    logic            out_valid;
    logic [XLEN-1:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic            exp_valid;
    logic [XLEN-1:0] exp_data;
    string           exp_tag;

    wsx_unit #(.XLEN(XLEN)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_fix_sel (in_fix_sel),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    function automatic int field_width(input int op, input int sel);
        int lits[4];
        lits = '{8, 16, 32, XLEN};
        case (op)
            0: return XLEN / 8;
            1: return XLEN / 4;
            2: return XLEN / 2;
            default: return (lits[sel] >= XLEN) ? XLEN : lits[sel];
        endcase
    endfunction

    function automatic logic [XLEN-1:0] model(input int w, input logic [XLEN-1:0] d);
        logic signed [XLEN-1:0] t;
        int sh;
        if (w >= XLEN) return d;
        sh = XLEN - w;
        t = $signed(d << sh);
        return t >>> sh;
    endfunction

    function automatic string tag_of(input int op, input int sel);
        case (op)
            0: return "R1/R4";
            1: return "R2/R4";
            2: return "R3/R4";
            default: return (field_width(op, sel) >= XLEN && sel != 3 || sel == 3) ? "R6" : "R5";
        endcase
    endfunction

    task automatic compare();
        tests++;
        if (out_valid !== exp_valid) begin
            fails++;
            $display("FAIL R7 XLEN=%0d out_valid=%b expected=%b", XLEN, out_valid, exp_valid);
        end
        tests++;
        if (out_data !== exp_data) begin
            fails++;
            $display("FAIL %s XLEN=%0d out_data=%h expected=%h", exp_tag, XLEN, out_data, exp_data);
        end
    endtask

    task automatic step(input bit v, input int op, input int sel, input logic [XLEN-1:0] d);
        @(negedge clk);
        compare();
        in_valid   = v;
        in_op      = op[1:0];
        in_fix_sel = sel[1:0];
        in_data    = d;
        exp_valid  = v;
        if (v) begin
            exp_data = model(field_width(op, sel), d);
            exp_tag  = tag_of(op, sel);
        end else begin
            exp_tag  = "R8";
        end
    endtask

    initial begin
        logic [XLEN-1:0] junk;
        in_valid = 0; in_op = 0; in_fix_sel = 0; in_data = '0;
        exp_valid = 0; exp_data = '0; exp_tag = "R9";
        junk = {(XLEN/8){8'hA5}};
        // R9: outputs cleared while reset is held
        @(negedge clk);
        compare();
        wait (rst_n === 1'b1);
        for (int op = 0; op < 4; op++) begin
            for (int sel = 0; sel < 4; sel++) begin
                int w;
                logic [XLEN-1:0] mask;
                if (op != 3 && sel != 0) continue;
                w = field_width(op, sel);
                mask = (w >= XLEN) ? '1 : ((XLEN'(1) << w) - XLEN'(1));
                // positive, negative, zero and all-ones fields, junk above
                step(1, op, sel, (junk & ~mask) | (mask >> 1));
                step(1, op, sel, (junk & ~mask) | (mask & ~(mask >> 1)));
                step(1, op, sel, junk & ~mask);
                step(1, op, sel, '1);
                step(1, op, sel, ~junk);
                // R8: idle cycles keep the last result
                step(0, op, sel, junk);
                step(0, 3 - op, sel, ~junk);
            end
        end
        // R5: fix_sel is ignored outside fixed mode
        step(1, 0, 3, junk);
        step(1, 1, 2, junk);
        step(1, 2, 1, ~junk);
        step(0, 0, 0, '0);
        @(negedge clk);
        compare();
        done = 1;
    end
endmodule

module wsx_unit_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    int   total_tests;
    int   total_fails;
    bit   timed_out = 0;

    always #5 clk = ~clk;

    wsx_unit_tb #(.XLEN(8))  b8  (.clk(clk), .rst_n(rst_n));
    wsx_unit_tb #(.XLEN(16)) b16 (.clk(clk), .rst_n(rst_n));
    wsx_unit_tb #(.XLEN(32)) b32 (.clk(clk), .rst_n(rst_n));
    wsx_unit_tb #(.XLEN(64)) b64 (.clk(clk), .rst_n(rst_n));

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
    end

    initial begin
        fork
            wait (b8.done && b16.done && b32.done && b64.done);
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        total_tests = b8.tests + b16.tests + b32.tests + b64.tests;
        total_fails = b8.fails + b16.fails + b32.fails + b64.fails;
        if (timed_out) begin
            total_tests++;
            total_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", total_tests, total_fails);
        $finish;
    end
endmodule